// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block keeps calendar time in packed BCD: seconds, minutes, hours, day of week, date, month, year and century. A one-cycle `tick` pulse, once per second, advances an internal count with full calendar rollover. Month lengths follow the Gregorian rules, leap years included. Software reaches the block over a simple byte-wide register bus. It reads a separate visible copy of the time, which tracks the internal count while the run bit is set.

Clearing the run bit freezes the visible copy, so software gets a consistent snapshot. The internal count keeps advancing during the freeze. A freeze is also the only window in which the time can be written. When the run bit is set again, the count is reloaded from the visible copy if any time field was written during the freeze. If no field was written, the visible copy catches up with the count.

Four alarm registers cover seconds, minutes, hours and date. Each has a don't-care bit in bit 7. The unmasked fields are compared against the count one cycle after each tick update. A match sets a status flag, and reading the status register clears that flag. The interrupt output is the flag gated by an enable bit.

Top module: `bcd_rtc`

## Requirements
- R1: On each `tick` the seconds count advances in BCD, wrapping 59 to 00 and carrying into minutes. Minutes wrap 59 to 00 and carry into hours, and hours wrap 23 to 00. The count does not change without a tick or a reload.
- R2: At the end of the day the date (offset 0x4) advances and wraps to 01 after the last day of the month. April, June, September and November have 30 days. February has 29 days in a leap year and 28 otherwise. Leap years are: year (0x6) a multiple of 4 when year is not 00, or century (0x7) a multiple of 4 when year is 00. Month (0x5, bits 4:0) wraps 12 to 01 and increments the year. Year wraps 99 to 00 and increments the century.
- R3: Writing 0 to bit 7 of the control register (0xF) freezes the values read at offsets 0x0 to 0x7, while the internal count keeps advancing on ticks.
- R4: Time writes are accepted only while bit 7 of 0xF is 0, and are stored masked to the significant bits: 0x7F for seconds and minutes, 0x3F for hours and date, 0x07 for day of week, and the full byte for month, year and century. Time writes made while bit 7 is 1 have no effect.
- R5: Writing 1 to bit 7 of 0xF after a frozen period reloads the count from the written values if any time offset was written; otherwise the visible values resynchronise to the count that kept running. Month bits 7:5 are carried unchanged through every rollover.
- R6: Day of week (0x3) advances at each midnight and wraps 7 to 1.
- R7: Alarm registers sit at 0x8 (seconds), 0x9 (minutes), 0xA (hours) and 0xB (date). Bit 7 of each makes that field a don't-care, and the low bits are compared with the count. One cycle after a tick update, a match of all fields sets the flag at bit 0 of 0xE. With all four masks set, the flag sets on every tick.
- R8: A read of 0xE (with `re` high) returns the flag and clears it, unless a new match sets it in the same cycle.
- R9: `irq` is high exactly when the flag is set and the alarm enable (bit 3 of 0xF) is 1. Reading 0xF returns the run bit in bit 7 and the enable in bit 3.
- R10: After reset the time reads 00:00:00, day of week 1, date 01, month 01, year 00, century 20. The run bit is 1, the alarm enable is 0, the flag is 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse each second |
| we | input | 1 | Register write strobe |
| re | input | 1 | Register read strobe (needed for read-to-clear) |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| irq | output | 1 | Alarm interrupt, flag gated by enable |

## Verification
The calendar carry chain is driven from start times placed just before each boundary. These cover a plain seconds step and the end of February in a common year and in a leap year. They also cover a year 00 leap year and a year 00 common year, a 30-day month, and the end of a century. Comparing these cases separates the year-based leap rule from the century-based one, and shows whether the month control bits survive. Freeze tests tell a reload of written values apart from a resync to the running count. An ignored write during run shows that the write gate works. Alarm patterns include a single unmasked field that matches, a second unmasked field that does not, and all fields masked. Repeating with the enable off separates the flag from the interrupt pin.

// File: rtl/bcd_rtc.sv
module bcd_rtc #(
  parameter logic [7:0] RST_CENTURY = 8'h20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       we,
  input  logic       re,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq
);

  localparam logic [3:0] A_STAT = 4'hE;
  localparam logic [3:0] A_CTRL = 4'hF;

  logic [7:0] cnt [8];
  logic [7:0] usr [8];
  logic [7:0] nxt [8];
  logic [7:0] alm [4];
  logic       run, aie, dirty, flag, tick_q;
  logic       leap, match, load, time_wr, ctrl_wr;
  logic       w_sec, w_min, w_hr, w_date, w_mon, w_yr;
  logic [7:0] last_day;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return (v[7:4] >= 4'd9) ? 8'h00 : {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [1:0] bcd_mod4(input logic [7:0] v);
    return {v[4], 1'b0} + v[1:0];
  endfunction

  function automatic logic [7:0] reset_val(input int i);
    case (i)
      3, 4, 5: return 8'h01;
      7:       return RST_CENTURY;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] wr_mask(input logic [2:0] a);
    case (a)
      3'd0, 3'd1: return 8'h7F;
      3'd2, 3'd4: return 8'h3F;
      3'd3:       return 8'h07;
      default:    return 8'hFF;
    endcase
  endfunction

  assign ctrl_wr = we && addr == A_CTRL;
  assign time_wr = we && !addr[3] && !run;
  assign load    = ctrl_wr && wdata[7] && !run && dirty;

  assign leap = (cnt[6] == 8'h00) ? (bcd_mod4(cnt[7]) == 2'd0) : (bcd_mod4(cnt[6]) == 2'd0);

  always_comb begin
    case (cnt[5][4:0])
      5'h02:                      last_day = leap ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end

  assign w_sec  = cnt[0] == 8'h59;
  assign w_min  = w_sec && cnt[1] == 8'h59;
  assign w_hr   = w_min && cnt[2] == 8'h23;
  assign w_date = w_hr && cnt[4] == last_day;
  assign w_mon  = w_date && cnt[5][4:0] == 5'h12;
  assign w_yr   = w_mon && cnt[6] == 8'h99;

  always_comb begin
    nxt = cnt;
    nxt[0] = w_sec ? 8'h00 : bcd_inc(cnt[0]);
    if (w_sec) nxt[1] = w_min ? 8'h00 : bcd_inc(cnt[1]);
    if (w_min) nxt[2] = w_hr ? 8'h00 : bcd_inc(cnt[2]);
    if (w_hr) begin
      nxt[3] = (cnt[3] >= 8'h07) ? 8'h01 : cnt[3] + 8'h01;
      nxt[4] = w_date ? 8'h01 : bcd_inc(cnt[4]);
    end
    if (w_date)
      nxt[5][4:0] = w_mon ? 5'h01 : ((cnt[5][3:0] == 4'h9) ? 5'h10 : cnt[5][4:0] + 5'h01);
    if (w_mon) nxt[6] = w_yr ? 8'h00 : bcd_inc(cnt[6]);
    if (w_yr)  nxt[7] = bcd_inc(cnt[7]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) cnt[i] <= reset_val(i);
    end else if (load) begin
      for (int i = 0; i < 8; i++) cnt[i] <= usr[i];
    end else if (tick) begin
      for (int i = 0; i < 8; i++) cnt[i] <= nxt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) usr[i] <= reset_val(i);
    end else if (run) begin
      for (int i = 0; i < 8; i++) usr[i] <= cnt[i];
    end else if (time_wr) begin
      usr[addr[2:0]] <= wdata & wr_mask(addr[2:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run    <= 1'b1;
      aie    <= 1'b0;
      dirty  <= 1'b0;
      tick_q <= 1'b0;
      flag   <= 1'b0;
      for (int i = 0; i < 4; i++) alm[i] <= 8'h00;
    end else begin
      tick_q <= tick;
      if (ctrl_wr) begin
        run <= wdata[7];
        aie <= wdata[3];
      end
      if (time_wr) dirty <= 1'b1;
      else if (ctrl_wr && wdata[7]) dirty <= 1'b0;
      if (we && addr[3:2] == 2'b10) alm[addr[1:0]] <= wdata;
      if (match) flag <= 1'b1;
      else if (re && addr == A_STAT) flag <= 1'b0;
    end
  end

  assign match = tick_q
    && (alm[0][7] || alm[0][6:0] == cnt[0][6:0])
    && (alm[1][7] || alm[1][6:0] == cnt[1][6:0])
    && (alm[2][7] || alm[2][5:0] == cnt[2][5:0])
    && (alm[3][7] || alm[3][5:0] == cnt[4][5:0]);

  assign irq = flag && aie;

  always_comb begin
    if (!addr[3])               rdata = usr[addr[2:0]];
    else if (addr[3:2] == 2'b10) rdata = alm[addr[1:0]];
    else if (addr == A_STAT)    rdata = {7'd0, flag};
    else if (addr == A_CTRL)    rdata = {run, 3'd0, aie, 3'd0};
    else                        rdata = 8'h00;
  end

  AST_SEC_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt[0])); // R1
  AST_FROZEN_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !time_wr) |=> $stable(usr[0])); // R3
  AST_MONTH_CTRL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load) |=> cnt[5][7:5] == $past(cnt[5][7:5])); // R5
  AST_DOW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && w_hr && cnt[3] == 8'h07) |=> cnt[3] == 8'h01); // R6
  AST_FLAG_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(tick_q)); // R7
  AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (re && addr == A_STAT && !match) |=> !flag); // R8

endmodule

// File: tb/bcd_rtc_test.sv
module bcd_rtc_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       we = 1'b0;
  logic       re = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;
  int         checks = 0;
  int         errors = 0;
  logic       aie_b = 1'b0;
  logic [7:0] d;

  bcd_rtc uut (.clk(clk), .rst_n(rst_n), .tick(tick), .we(we), .re(re),
               .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] v);
    we = 1'b1; addr = a; wdata = v;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    re = 1'b1; addr = a;
    #1 v = rdata;
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic expect_reg(input string tag, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic pulse();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                          input logic [7:0] dw, input logic [7:0] dt, input logic [7:0] mo,
                          input logic [7:0] y, input logic [7:0] c);
    wr(4'hF, {1'b0, 3'd0, aie_b, 3'd0});
    wr(4'h0, s); wr(4'h1, m); wr(4'h2, h); wr(4'h3, dw);
    wr(4'h4, dt); wr(4'h5, mo); wr(4'h6, y); wr(4'h7, c);
    wr(4'hF, {1'b1, 3'd0, aie_b, 3'd0});
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    expect_reg("R10 sec", 4'h0, 8'h00);
    expect_reg("R10 hour", 4'h2, 8'h00);
    expect_reg("R10 dow", 4'h3, 8'h01);
    expect_reg("R10 date", 4'h4, 8'h01);
    expect_reg("R10 month", 4'h5, 8'h01);
    expect_reg("R10 year", 4'h6, 8'h00);
    expect_reg("R10 century", 4'h7, 8'h20);
    expect_reg("R10 ctrl", 4'hF, 8'h80);
    expect_reg("R10 status", 4'hE, 8'h00);
    chk("R10 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_masking();
    wr(4'hF, 8'h00);
    wr(4'h0, 8'hD8);
    wr(4'h2, 8'hE3);
    wr(4'h3, 8'hFF);
    wr(4'h5, 8'hE2);
    expect_reg("R4 sec mask", 4'h0, 8'h58);
    expect_reg("R4 hour mask", 4'h2, 8'h23);
    expect_reg("R4 dow mask", 4'h3, 8'h07);
    expect_reg("R4 month full byte", 4'h5, 8'hE2);
    wr(4'hF, 8'h80);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_feb_common();
    set_time(8'h58, 8'h59, 8'h23, 8'h07, 8'h28, 8'hE2, 8'h23, 8'h20);
    pulse();
    expect_reg("R1 sec step", 4'h0, 8'h59);
    expect_reg("R1 min held", 4'h1, 8'h59);
    pulse();
    expect_reg("R1 sec wrap", 4'h0, 8'h00);
    expect_reg("R1 min wrap", 4'h1, 8'h00);
    expect_reg("R1 hour wrap", 4'h2, 8'h00);
    expect_reg("R2 common feb end", 4'h4, 8'h01);
    expect_reg("R5 month ctrl bits kept", 4'h5, 8'hE3);
    expect_reg("R6 dow wrap", 4'h3, 8'h01);
  endtask

  task automatic t_leap();
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24, 8'h20);
    pulse();
    expect_reg("R2 leap year 24", 4'h4, 8'h29);
    expect_reg("R6 dow step", 4'h3, 8'h03);
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h00, 8'h20);
    pulse();
    expect_reg("R2 leap century 20", 4'h4, 8'h29);
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h00, 8'h21);
    pulse();
    expect_reg("R2 common century 21 date", 4'h4, 8'h01);
    expect_reg("R2 common century 21 month", 4'h5, 8'h03);
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h25, 8'h20);
    pulse();
    expect_reg("R2 thirty day date", 4'h4, 8'h01);
    expect_reg("R2 thirty day month", 4'h5, 8'h05);
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h31, 8'h09, 8'h25, 8'h20);
    expect_reg("R2 sept 31 is kept on write", 4'h4, 8'h31);
  endtask

  task automatic t_century();
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h31, 8'h12, 8'h99, 8'h20);
    pulse();
    expect_reg("R2 new year date", 4'h4, 8'h01);
    expect_reg("R2 new year month", 4'h5, 8'h01);
    expect_reg("R2 year wrap", 4'h6, 8'h00);
    expect_reg("R2 century step", 4'h7, 8'h21);
    expect_reg("R6 dow after new year", 4'h3, 8'h04);
  endtask

  task automatic t_freeze();
    set_time(8'h10, 8'h05, 8'h08, 8'h01, 8'h10, 8'h06, 8'h25, 8'h20);
    wr(4'hF, 8'h00);
    pulse();
    pulse();
    expect_reg("R3 frozen sec", 4'h0, 8'h10);
    wr(4'hF, 8'h80);
    repeat (2) @(negedge clk);
    expect_reg("R5 resync sec", 4'h0, 8'h12);
    wr(4'h0, 8'h33);
    repeat (2) @(negedge clk);
    expect_reg("R4 write while running ignored", 4'h0, 8'h12);
    pulse();
    expect_reg("R4 count unaffected", 4'h0, 8'h13);
  endtask

  task automatic t_alarm();
    aie_b = 1'b1;
    wr(4'h8, 8'h05); wr(4'h9, 8'h80); wr(4'hA, 8'h80); wr(4'hB, 8'h80);
    set_time(8'h04, 8'h00, 8'h10, 8'h02, 8'h15, 8'h03, 8'h25, 8'h20);
    rd(4'hE, d);
    chk("R9 irq low before match", {7'd0, irq}, 8'h00);
    pulse();
    chk("R9 irq on match", {7'd0, irq}, 8'h01);
    expect_reg("R7 flag on sec match", 4'hE, 8'h01);
    chk("R8 irq after read", {7'd0, irq}, 8'h00);
    expect_reg("R8 flag cleared", 4'hE, 8'h00);
    pulse();
    expect_reg("R7 no flag on mismatch", 4'hE, 8'h00);
    wr(4'h8, 8'h07); wr(4'h9, 8'h10);
    pulse();
    expect_reg("R7 unmasked minute blocks", 4'hE, 8'h00);
    wr(4'h8, 8'h80); wr(4'h9, 8'h80);
    pulse();
    expect_reg("R7 all masked fires", 4'hE, 8'h01);
    pulse();
    expect_reg("R7 all masked every tick", 4'hE, 8'h01);
    aie_b = 1'b0;
    wr(4'hF, 8'h80);
    expect_reg("R9 ctrl readback", 4'hF, 8'h80);
    pulse();
    chk("R9 irq gated off", {7'd0, irq}, 8'h00);
    expect_reg("R9 flag still set", 4'hE, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_masking();
    t_feb_common();
    t_leap();
    t_century();
    t_freeze();
    t_alarm();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    checks++;
    errors++;
    $display("FAIL watchdog expired got 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule